// File: doc/BRIEF.md
# Integer ALU Instruction Executor

This block executes one 32-bit instruction word per clock for a small integer subset of a classic three-operand RISC instruction set. It decodes the register-register (opcode zero, operation chosen by the function field) and register-immediate formats. It reads its source operands from a 32-entry register file and computes an arithmetic, logical or load-upper-immediate result. In the same clock edge it writes the result back to the destination that the format selects.

A 32-bit constant is built in two instructions: a load-upper-immediate sets the high half, and an OR-immediate fills the low half. A bitwise NOT is a NOR against register zero. Two single-cycle flags report signed overflow from the trapping add and subtract forms, and undecodable words. In both of those cases no register is written. A combinational debug port reads any register and shows the contents committed at the last clock edge.

Top module: `int_exec_unit`

## Requirements
- R1: Field positions are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and immediate [15:0]. With opcode 0 the result goes to rd; with any other opcode it goes to rt.
- R2: Opcode 0 uses these funct codes: 0x20 ADD and 0x21 ADDU (rs+rt), 0x22 SUB and 0x23 SUBU (rs-rt). All four produce the result modulo 2^32.
- R3: Opcode 0 uses funct 0x24 AND, 0x25 OR, 0x26 XOR and 0x27 NOR, each bitwise on rs and rt. A NOR with register 0 as one operand yields the complement of the other operand.
- R4: The add-immediate opcodes 0x08 ADDI and 0x09 ADDIU sign-extend the immediate. The logical-immediate opcodes 0x0C ANDI, 0x0D ORI and 0x0E XORI zero-extend it.
- R5: Opcode 0x0F (LUI) writes the immediate into bits 31:16 and zeros into bits 15:0. LUI followed by ORI on the same register builds a full 32-bit constant.
- R6: Register 0 always reads as zero, and any write to it is discarded.
- R7: When ADD, SUB or ADDI overflow as signed numbers, the overflow output is high for the following cycle and the destination keeps its value. ADDU, SUBU and ADDIU never raise the flag, and they write the wrapped result.
- R8: An opcode or funct value outside the ones listed writes no register and holds the illegal output high for the following cycle.
- R9: While the valid input is low, no register changes and both flags stay low.
- R10: Reset sets every register to zero. A write made at a clock edge appears on the debug port after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | The instruction word is executed at this edge |
| instr_word | input | 32 | Instruction to execute |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Current contents of the register at dbg_addr |
| ovf_flag | output | 1 | Signed overflow on the previous instruction; write suppressed |
| illegal_flag | output | 1 | Previous instruction was not decodable; write suppressed |

## Verification
On every cycle, the assertions check three things. Register 0 reads as zero on the debug port. The two flags are never high together, and a flag rises only after a valid instruction. The register file also stays unchanged on any edge where no write is enabled. Only the directed scenarios can show that each encoding computes the right value. They also show that immediates are extended the correct way per opcode, that LUI and ORI combine into a full constant, and that overflow and illegal words leave their destination untouched. Finally, they show that a write appears on the debug port only after its clock edge.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ADDIU = 6'h09;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LUI   = 6'h0F;

    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_NOR,
        ALU_PASSB
    } alu_op_e;

    typedef struct packed {
        logic              legal;
        logic              trap_ovf;
        logic              use_imm;
        alu_op_e           op;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   imm_ext;
    } decode_t;

    typedef struct packed {
        logic ovf;
        logic ill;
    } flag_t;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
    import int_exec_pkg::*;
(
    input  logic [XLEN-1:0] word,
    output decode_t         dec
);
    logic [5:0]       opc;
    logic [5:0]       fn;
    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  imm_sx;
    logic [XLEN-1:0]  imm_zx;
    logic [XLEN-1:0]  imm_hi;

    always_comb begin
        opc    = word[31:26];
        fn     = word[5:0];
        imm    = word[IMM_W-1:0];
        imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        imm_zx = {{(XLEN-IMM_W){1'b0}}, imm};
        imm_hi = {imm, {(XLEN-IMM_W){1'b0}}};

        dec          = '0;
        dec.src_a    = word[25:21];
        dec.src_b    = word[20:16];
        dec.legal    = 1'b1;
        dec.op       = ALU_ADD;

        if (opc == OPC_RTYPE) begin
            dec.dst = word[15:11];
            unique case (fn)
                FN_ADD:  begin dec.op = ALU_ADD; dec.trap_ovf = 1'b1; end
                FN_ADDU: dec.op = ALU_ADD;
                FN_SUB:  begin dec.op = ALU_SUB; dec.trap_ovf = 1'b1; end
                FN_SUBU: dec.op = ALU_SUB;
                FN_AND:  dec.op = ALU_AND;
                FN_OR:   dec.op = ALU_OR;
                FN_XOR:  dec.op = ALU_XOR;
                FN_NOR:  dec.op = ALU_NOR;
                default: dec.legal = 1'b0;
            endcase
        end else begin
            dec.dst     = word[20:16];
            dec.use_imm = 1'b1;
            unique case (opc)
                OPC_ADDI:  begin dec.op = ALU_ADD; dec.trap_ovf = 1'b1; dec.imm_ext = imm_sx; end
                OPC_ADDIU: begin dec.op = ALU_ADD;   dec.imm_ext = imm_sx; end
                OPC_ANDI:  begin dec.op = ALU_AND;   dec.imm_ext = imm_zx; end
                OPC_ORI:   begin dec.op = ALU_OR;    dec.imm_ext = imm_zx; end
                OPC_XORI:  begin dec.op = ALU_XOR;   dec.imm_ext = imm_zx; end
                OPC_LUI:   begin dec.op = ALU_PASSB; dec.imm_ext = imm_hi; end
                default:   dec.legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import int_exec_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] res,
    output logic            sovf
);
    localparam int MSB = XLEN - 1;

    always_comb begin
        res  = '0;
        sovf = 1'b0;
        unique case (op)
            ALU_ADD: begin
                res  = opa + opb;
                sovf = (opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]);
            end
            ALU_SUB: begin
                res  = opa - opb;
                sovf = (opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB]);
            end
            ALU_AND:   res = opa & opb;
            ALU_OR:    res = opa | opb;
            ALU_XOR:   res = opa ^ opb;
            ALU_NOR:   res = ~(opa | opb);
            ALU_PASSB: res = opb;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_regfile.sv
module int_exec_regfile
    import int_exec_pkg::*;
#(
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [AW-1:0]   ra_addr,
    input  logic [AW-1:0]   rb_addr,
    input  logic [AW-1:0]   rc_addr,
    output logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] rb_data,
    output logic [XLEN-1:0] rc_data
);
    logic [NREG-1:0][XLEN-1:0] regs_d;
    logic [NREG-1:0][XLEN-1:0] regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_addr != '0)) begin
            regs_d[wr_addr] = wr_data;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = regs_q[ra_addr];
    assign rb_data = regs_q[rb_addr];
    assign rc_data = regs_q[rc_addr];

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr_word,
    input  logic [AW-1:0]   dbg_addr,
    output logic [XLEN-1:0] dbg_data,
    output logic            ovf_flag,
    output logic            illegal_flag
);
    decode_t         dec;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] alu_res;
    logic            alu_ovf;
    logic            wr_en;
    flag_t           flags_d;
    flag_t           flags_q;

    int_exec_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    int_exec_regfile #(.NREG(NREG), .AW(AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (dec.dst),
        .wr_data (alu_res),
        .ra_addr (dec.src_a),
        .rb_addr (dec.src_b),
        .rc_addr (dbg_addr),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .rc_data (dbg_data)
    );

    assign opb = dec.use_imm ? dec.imm_ext : rt_val;

    int_exec_alu u_alu (
        .op   (dec.op),
        .opa  (rs_val),
        .opb  (opb),
        .res  (alu_res),
        .sovf (alu_ovf)
    );

    always_comb begin
        flags_d.ovf = instr_valid && dec.legal && dec.trap_ovf && alu_ovf;
        flags_d.ill = instr_valid && !dec.legal;
        wr_en       = instr_valid && dec.legal && !(dec.trap_ovf && alu_ovf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign ovf_flag     = flags_q.ovf;
    assign illegal_flag = flags_q.ill;

    // R6
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> (dbg_data == '0));

    // R7
    ovf_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> $past(instr_valid));

    // R8
    illegal_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_flag |-> $past(instr_valid));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && illegal_flag));
endmodule

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_data;
    logic        ovf_flag;
    logic        illegal_flag;

    int checks = 0;
    int failures = 0;
    logic last_ovf;
    logic last_ill;
    bit   done = 0;

    always #5 clk = ~clk;

    int_exec_unit i_int_exec_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr_word   (instr_word),
        .dbg_addr     (dbg_addr),
        .dbg_data     (dbg_data),
        .ovf_flag     (ovf_flag),
        .illegal_flag (illegal_flag)
    );

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] opc, input int rs, input int rt, input logic [15:0] imm);
        return {opc, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [31:0] val);
        dbg_addr = 5'(idx);
        #1;
        val = dbg_data;
    endtask

    task automatic check_reg(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        read_reg(idx, v);
        check(req, $sformatf("r%0d", idx), v, exp);
    endtask

    // drive at a falling edge, capture at the rising edge, sample at the next falling edge
    task automatic issue(input logic [31:0] w);
        instr_word  = w;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        last_ovf = ovf_flag;
        last_ill = illegal_flag;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) check_reg("R10", i, 32'h0);
        check("R10", "ovf after reset", 32'(ovf_flag), 32'h0);
        check("R10", "ill after reset", 32'(illegal_flag), 32'h0);
    endtask

    task automatic t_constants;
        issue(itype(6'h0F, 0, 2, 16'h02AB));
        check_reg("R5", 2, 32'h02AB0000);
        issue(itype(6'h0D, 2, 2, 16'hCD87));
        check_reg("R5", 2, 32'h02ABCD87);
        issue(itype(6'h09, 0, 3, 16'd14));
        check_reg("R4", 3, 32'd14);
        issue(32'h00621026);
        check_reg("R1", 2, 32'h02ABCD89);
        check_reg("R1", 3, 32'd14);
    endtask

    task automatic t_immediates;
        issue(itype(6'h09, 0, 4, 16'hFFE8));
        check_reg("R4", 4, 32'hFFFFFFE8);
        issue(itype(6'h0C, 4, 5, 16'hFFE8));
        check_reg("R4", 5, 32'h0000FFE8);
        issue(itype(6'h0E, 0, 6, 16'h8000));
        check_reg("R4", 6, 32'h00008000);
        issue(itype(6'h08, 0, 7, 16'h8000));
        check_reg("R4", 7, 32'hFFFF8000);
        check("R7", "ovf after ADDI negative", 32'(last_ovf), 32'h0);
    endtask

    task automatic t_arith;
        issue(rtype(3, 4, 8, 6'h21));
        check_reg("R2", 8, 32'hFFFFFFF6);
        issue(rtype(3, 4, 9, 6'h23));
        check_reg("R2", 9, 32'h00000026);
        issue(rtype(3, 4, 10, 6'h20));
        check_reg("R2", 10, 32'hFFFFFFF6);
        issue(rtype(4, 3, 11, 6'h22));
        check_reg("R2", 11, 32'hFFFFFFDA);
    endtask

    task automatic t_logic;
        issue(rtype(2, 4, 12, 6'h24));
        check_reg("R3", 12, 32'h02ABCD88);
        issue(rtype(3, 6, 13, 6'h25));
        check_reg("R3", 13, 32'h0000800E);
        issue(rtype(0, 3, 14, 6'h27));
        check_reg("R3", 14, 32'hFFFFFFF1);
    endtask

    task automatic t_overflow;
        issue(itype(6'h0F, 0, 15, 16'h7FFF));
        issue(itype(6'h0D, 15, 15, 16'hFFFF));
        check_reg("R5", 15, 32'h7FFFFFFF);
        issue(itype(6'h09, 0, 16, 16'd1));
        issue(rtype(15, 16, 17, 6'h20));
        check("R7", "ovf on ADD", 32'(last_ovf), 32'h1);
        check_reg("R7", 17, 32'h0);
        issue(rtype(15, 16, 18, 6'h21));
        check("R7", "ovf on ADDU", 32'(last_ovf), 32'h0);
        check_reg("R7", 18, 32'h80000000);
        issue(itype(6'h08, 15, 17, 16'd1));
        check("R7", "ovf on ADDI", 32'(last_ovf), 32'h1);
        check_reg("R7", 17, 32'h0);
        issue(itype(6'h0F, 0, 20, 16'h8000));
        issue(rtype(20, 16, 19, 6'h22));
        check("R7", "ovf on SUB", 32'(last_ovf), 32'h1);
        check_reg("R7", 19, 32'h0);
        issue(rtype(20, 16, 19, 6'h23));
        check("R7", "ovf on SUBU", 32'(last_ovf), 32'h0);
        check_reg("R7", 19, 32'h7FFFFFFF);
        @(negedge clk);
        check("R7", "ovf one cycle", 32'(ovf_flag), 32'h0);
    endtask

    task automatic t_illegal;
        issue(itype(6'h23, 0, 21, 16'd5));
        check("R8", "ill on bad opcode", 32'(last_ill), 32'h1);
        check_reg("R8", 21, 32'h0);
        issue(rtype(3, 3, 21, 6'h00));
        check("R8", "ill on bad funct", 32'(last_ill), 32'h1);
        check_reg("R8", 21, 32'h0);
        @(negedge clk);
        check("R8", "ill one cycle", 32'(illegal_flag), 32'h0);
    endtask

    task automatic t_zero_reg;
        issue(itype(6'h09, 0, 0, 16'd5));
        check_reg("R6", 0, 32'h0);
        check("R6", "no flag on r0 write", 32'({last_ovf, last_ill}), 32'h0);
    endtask

    task automatic t_idle;
        instr_word  = itype(6'h09, 0, 22, 16'd7);
        instr_valid = 1'b0;
        @(negedge clk);
        check_reg("R9", 22, 32'h0);
        instr_word = itype(6'h3F, 0, 22, 16'd7);
        @(negedge clk);
        check("R9", "ill while idle", 32'(illegal_flag), 32'h0);
        check_reg("R9", 22, 32'h0);
    endtask

    task automatic t_visibility;
        logic [31:0] v;
        instr_word  = itype(6'h09, 0, 23, 16'd9);
        instr_valid = 1'b1;
        read_reg(23, v);
        check("R10", "before edge", v, 32'h0);
        @(negedge clk);
        instr_valid = 1'b0;
        check_reg("R10", 23, 32'd9);
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_constants();
        t_immediates();
        t_arith();
        t_logic();
        t_overflow();
        t_illegal();
        t_zero_reg();
        t_idle();
        t_visibility();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule